// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the addresses of a four-beat burst from one start address. A load pulse captures the full start address. Each qualified advance cycle after that moves the burst to its next beat. Only the two least significant address bits change during a burst. The upper bits stay as captured, so a burst never crosses into a neighbouring aligned group of four words.

A static order input chooses between two sequences. In counting order the low bits increase by one and wrap modulo four. In the XOR order the low bits of beat n are the start bits XOR n. Either order may begin at any of the four positions.

A suspend input freezes the whole block for as long as it is held. The block also outputs a beat index, so downstream logic can tell which beat of the burst is being accessed. All control pins are plain levels sampled on the rising clock edge. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `addr_o` and `beat_o` read 0 until the first load.
- R2: A rising edge with `suspend_i`=0 and `load_i`=1 captures `base_addr_i`. From the next cycle `addr_o` equals the captured address and `beat_o` equals 0.
- R3: A rising edge with `suspend_i`=0, `load_i`=0 and `step_i`=1 increases `beat_o` by one modulo 4.
- R4: With `mode_i`=0 (counting order), `addr_o[1:0]` equals (start low bits + `beat_o`) mod 4. A start of 2 gives 2, 3, 0, 1.
- R5: With `mode_i`=1 (XOR order), `addr_o[1:0]` equals start low bits XOR `beat_o`. A start of 1 gives 1, 0, 3, 2.
- R6: `addr_o[AW-1:2]` keeps the captured upper bits for the whole burst. No carry from the low bits reaches them, even when the upper bits are all ones.
- R7: The fourth advance after a load returns `addr_o` to the start address and `beat_o` to 0.
- R8: While `suspend_i`=1, `addr_o` and `beat_o` keep their values, and `load_i` and `step_i` have no effect.
- R9: When `load_i` and `step_i` are both 1 in an unsuspended cycle, the load wins and `beat_o` becomes 0.
- R10: An unsuspended cycle with `load_i`=0 and `step_i`=0 leaves `addr_o` and `beat_o` unchanged.
- R11: `mode_i` is used directly, without a register, and may change only while `beat_o` is 0. At beat 0, `addr_o` equals the start address in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures the start address and begins a burst |
| step_i | input | 1 | Moves to the next beat when not loading |
| suspend_i | input | 1 | Freezes all state while high |
| mode_i | input | 1 | Static order select: 0 counting, 1 XOR |
| base_addr_i | input | AW | Start address of the burst |
| addr_o | output | AW | Current access address |
| beat_o | output | 2 | Index of the current beat |

## Verification
Every result of a load, advance, idle or suspend cycle appears on `addr_o` and `beat_o` one cycle after the rising edge that sampled it. The order input changes the low address bits combinationally, but only in the same cycle. The bench drives its inputs on the falling edge and updates its reference model on the rising edge. It then compares both outputs at the next falling edge, which is exactly one register stage after the sampled edge. The bench changes the order input only when the model says the beat index is 0.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_COUNT = 1'b0,
    ORDER_XOR   = 1'b1
  } burst_order_e;

  localparam int unsigned BEAT_BITS = 2;
endpackage

// File: rtl/burst_anchor.sv
module burst_anchor #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_en,
  input  logic [AW-1:0] base_d,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_q <= '0;
    else if (capture_en) base_q <= base_d;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clear,
  input  logic          inc,
  output logic [LW-1:0] beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 beat_q <= '0;
    else if (en && clear)       beat_q <= '0;
    else if (en && inc)         beat_q <= beat_q + 1'b1;
  end

  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && clear |=> beat_q == '0);
  assert_step_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clear && inc |=> beat_q == LW'($past(beat_q) + 1'b1));
  assert_suspend_holds_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(beat_q));
  assert_idle_holds_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clear && !inc |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned LW = 2
) (
  input  logic [LW-1:0] start_low,
  input  logic [LW-1:0] beat,
  input  burst_order_e  order,
  output logic [LW-1:0] low_o
);
  logic [LW-1:0] count_low;
  logic [LW-1:0] xor_low;

  assign count_low = start_low + beat;

  for (genvar b = 0; b < LW; b++) begin : g_xor_bit
    assign xor_low[b] = start_low[b] ^ beat[b];
  end

  assign low_o = (order == ORDER_XOR) ? xor_low : count_low;

  always_comb begin
    if (beat == '0) begin
      assert_beat0_is_start_R11: assert (low_o == start_low);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic                 suspend_i,
  input  logic                 mode_i,
  input  logic [AW-1:0]        base_addr_i,
  output logic [AW-1:0]        addr_o,
  output logic [BEAT_BITS-1:0] beat_o
);
  localparam int unsigned LW = BEAT_BITS;

  logic          run;
  logic [AW-1:0] base_q;
  logic [LW-1:0] low_bits;
  burst_order_e  order;

  assign run   = !suspend_i;
  assign order = burst_order_e'(mode_i);

  burst_anchor #(.AW(AW)) anchor_i (
    .clk(clk), .rst_n(rst_n), .capture_en(run && load_i),
    .base_d(base_addr_i), .base_q(base_q)
  );

  burst_beat_ctr #(.LW(LW)) beat_i (
    .clk(clk), .rst_n(rst_n), .en(run), .clear(load_i),
    .inc(step_i), .beat_q(beat_o)
  );

  burst_order_map #(.LW(LW)) map_i (
    .start_low(base_q[LW-1:0]), .beat(beat_o), .order(order), .low_o(low_bits)
  );

  assign addr_o = {base_q[AW-1:LW], low_bits};

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && load_i |=> addr_o == $past(base_addr_i));
  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && load_i) |=> addr_o[AW-1:LW] == $past(addr_o[AW-1:LW]));
  assert_suspend_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |=> $stable(addr_o));
  assert_mode_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o != '0 |-> $stable(mode_i));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0, step_i = 1'b0, suspend_i = 1'b0, mode_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  string tag_q = "R1";

  logic [AW-1:0] ref_base = '0;
  int            ref_beat = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .suspend_i(suspend_i), .mode_i(mode_i), .base_addr_i(base_addr_i),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  // behavioural reference: state updates on the rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_base <= '0;
      ref_beat <= 0;
    end else if (!suspend_i) begin
      if (load_i) begin
        ref_base <= base_addr_i;
        ref_beat <= 0;
      end else if (step_i) begin
        ref_beat <= (ref_beat + 1) % 4;
      end
    end
  end

  function automatic logic [AW-1:0] expect_addr();
    int s;
    int lo;
    s  = int'(ref_base[1:0]);
    lo = mode_i ? (s ^ ref_beat) : ((s + ref_beat) % 4);
    return {ref_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check_now();
    logic [AW-1:0] ea;
    ea = expect_addr();
    n_checks++;
    if (addr_o !== ea) begin
      n_fails++;
      $display("FAIL %s addr_o actual %h expected %h", tag_q, addr_o, ea);
    end
    n_checks++;
    if (beat_o !== 2'(ref_beat)) begin
      n_fails++;
      $display("FAIL %s beat_o actual %0d expected %0d", tag_q, beat_o, ref_beat);
    end
  endtask

  // one clock: check previous cycle's result at the falling edge, then drive
  task automatic cyc(input logic ld, input logic st, input logic sp,
                     input logic md, input logic [AW-1:0] ba, input string tag);
    @(negedge clk);
    check_now();
    load_i = ld; step_i = st; suspend_i = sp; mode_i = md; base_addr_i = ba;
    tag_q = tag;
  endtask

  task automatic burst(input logic md, input logic [AW-1:0] ba, input string tag);
    cyc(1'b0, 1'b0, 1'b0, md, ba, "R11");    // mode may change: beat is 0
    cyc(1'b1, 1'b0, 1'b0, md, ba, "R2");
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, md, '0, tag);
    cyc(1'b0, 1'b1, 1'b0, md, '0, "R7");
  endtask

  initial begin
    tag_q = "R1";
    repeat (3) begin
      @(negedge clk);
      check_now();
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");

    burst(1'b0, 20'hABCDE, "R4");            // counting order, start 2
    burst(1'b1, 20'h12341, "R5");            // XOR order, start 1
    for (int s = 0; s < 4; s++) begin
      burst(1'b0, {18'h2A5A5, 2'(s)}, "R4");
      burst(1'b1, {18'h15A5A, 2'(s)}, "R5");
    end
    burst(1'b0, 20'hFFFFF, "R6");            // all-ones upper, no carry
    burst(1'b1, 20'hFFFFE, "R6");

    // suspend: load and step ignored mid-burst
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 20'h00401, "R2");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R3");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 20'h77777, "R8");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, "R8");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R10");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R10");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R3");
    // load wins over step
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 20'h0BEE3, "R9");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R3");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 20'h0C0D2, "R9");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R10");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, "R11");  // beat 0: mode flip, same address
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R11");
    @(negedge clk);
    check_now();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fails++;
      $display("FAIL watchdog run did not finish actual %0d expected <= 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule